// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from an external transmit queue, shifts them out most-significant bit first on a divided serial clock, and returns one captured word to an external receive queue for every word it sends. This holds even when the caller only wants to write, so a write path has to throw away one input word per output word. A start pulse with a word count launches a transfer. The engine raises chip select for the whole transfer, runs the words back to back and signals completion with a one-cycle done pulse.

Five quasi-static controls set the serial behaviour:
- The word length, coded as length minus one.
- The clock idle level.
- An input-first bit that decides whether the leading clock edge samples or launches data. Together with the idle level this covers the four classic SPI modes.
- An internal loopback.
- A programmable clock divider.

Chip select takes one of four lines through a two-bit selector, with a programmable active level and a force option. A no-tristate option keeps the output enables high while idle. Two sticky error bits report clock underrun (nothing to send when a word is due) and clock overrun (nowhere to put a received word).

Top module: `spi_shift_engine`

## Requirements
- R1: Each word has cfg_len_m1_i+1 bits and is shifted out most-significant bit first; the value 7 gives 8-bit words and 31 gives 32-bit words.
- R2: While no word is being shifted, sclk_o sits at cfg_clk_idle_hi_i. Inside a word each clock half period lasts cfg_div_i+1 core cycles.
- R3: With cfg_in_first_i=1 (modes 0 and 2) the input is sampled on the leading clock edge and the output changes on the trailing edge. With cfg_in_first_i=0 (modes 1 and 3) the output changes on the leading edge (except for the first bit) and the input is sampled on the trailing edge.
- R4: With cfg_loopback_i=1 the serial output feeds the receive shifter and miso_i has no effect, so each received word equals the transmitted word masked to the word length.
- R5: Bit i of cs_o is active for line i == cfg_cs_sel_i. The active level is 1 when cfg_cs_act_hi_i=1 and 0 otherwise, and every other line sits at the inactive level. The selected line is active from start until done, and at all times when cfg_cs_force_i=1.
- R6: With cfg_no_tri_i=1, sclk_oe_o, mosi_oe_o and cs_oe_o stay 1 at all times. With 0 they are 1 only while busy_o=1.
- R7: tx_pop_o is asserted only with tx_valid_i. Every word popped produces exactly one rx_push_o with the received bits in the low bits and zeros above the word length.
- R8: If rx_full_i is high when a word completes, err_o bit 1 (clock overrun) is set and that word is not pushed.
- R9: If the transmit queue is empty when a word is due, the engine stalls with sclk_o idle and busy_o high and sets err_o bit 0 (clock underrun). It resumes when data arrives.
- R10: start_i while idle loads xfer_words_i and clears err_o. done_o pulses once after that many words, immediately and with no clock edges for a count of zero. start_i while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_len_m1_i | input | 5 | Word length minus one |
| cfg_clk_idle_hi_i | input | 1 | Serial clock idle level |
| cfg_in_first_i | input | 1 | Sample on the leading edge when set |
| cfg_loopback_i | input | 1 | Internal loopback of serial output into input |
| cfg_cs_sel_i | input | 2 | Chip-select line index |
| cfg_cs_act_hi_i | input | 1 | Chip-select active level is high when set |
| cfg_cs_force_i | input | 1 | Hold the selected chip select active |
| cfg_no_tri_i | input | 1 | Keep output enables high while idle |
| cfg_div_i | input | 8 | Half period of the serial clock minus one, in core cycles |
| start_i | input | 1 | Launch a transfer |
| xfer_words_i | input | 16 | Number of words in the transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| tx_valid_i | input | 1 | Transmit queue holds a word |
| tx_data_i | input | 32 | Head word of the transmit queue |
| tx_pop_o | output | 1 | Take the head word of the transmit queue |
| rx_full_i | input | 1 | Receive queue cannot accept a word |
| rx_data_o | output | 32 | Received word |
| rx_push_o | output | 1 | Write rx_data_o into the receive queue |
| err_o | output | 2 | Bit 1 clock overrun, bit 0 clock underrun (sticky) |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| cs_oe_o | output | 1 | Chip-select output enable |

## Verification
The hardest situation to reach is an underrun stall in the middle of an active transfer, with chip select held and the clock parked at its idle level. The bench gets there by masking the transmit queue's valid flag before start. It then watches for the error bit, the absence of any clock edge and the held busy state, and unmasks the queue to show that the words still complete in order. An overrun is forced by holding the receive queue full across a whole transfer. A second start issued mid-transfer with a larger count shows that the count is not reloaded.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_e;

  // positions inside the two-bit error vector
  localparam int unsigned ERR_UNDER = 0;
  localparam int unsigned ERR_OVER  = 1;
  localparam int unsigned ERR_W     = 2;

endpackage

// File: rtl/spi_clk_div.sv
// Half-period tick generator for the serial clock.
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_shift_dp.sv
// Transmit and receive shift registers, MSB first.
module spi_shift_dp #(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic [DATA_W-1:0] rx_next_o
);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              tx_en, rx_en;

  assign tx_en = load_i || shift_i;
  assign rx_en = load_i || sample_i;

  always_comb begin
    tx_d = load_i ? load_data_i : {tx_q[DATA_W-2:0], 1'b0};
    rx_d = load_i ? '0 : {rx_q[DATA_W-2:0], sin_i};
  end

  // the word seen at completion includes a sample taken in the same cycle
  assign rx_next_o = sample_i ? {rx_q[DATA_W-2:0], sin_i} : rx_q;
  assign sout_o    = tx_q[len_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (tx_en) begin
      tx_q <= tx_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (rx_en) begin
      rx_q <= rx_d;
    end
  end

endmodule

// File: rtl/spi_cs_ctl.sv
// Chip-select line decode with programmable active level.
module spi_cs_ctl #(
  parameter  int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              act_hi_i,
  input  logic              assert_i,
  output logic [NUM_CS-1:0] cs_o
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    logic hit;
    assign hit     = assert_i && (sel_i == SEL_W'(g));
    assign cs_o[g] = hit ? act_hi_i : ~act_hi_i;
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned DIV_W  = 8,
  parameter  int unsigned CNT_W  = 16,
  parameter  int unsigned NUM_CS = 4,
  localparam int unsigned LEN_W  = $clog2(DATA_W),
  localparam int unsigned SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_len_m1_i,
  input  logic              cfg_clk_idle_hi_i,
  input  logic              cfg_in_first_i,
  input  logic              cfg_loopback_i,
  input  logic [SEL_W-1:0]  cfg_cs_sel_i,
  input  logic              cfg_cs_act_hi_i,
  input  logic              cfg_cs_force_i,
  input  logic              cfg_no_tri_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  xfer_words_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_push_o,
  output logic [ERR_W-1:0]  err_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              cs_oe_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  bit_q, bit_d;
  logic              phase_q, phase_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              done_q, done_d;
  logic              push_q, push_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;

  logic              tick, lead, trail, in_shift;
  logic              last_bit, first_bit;
  logic              dp_load, dp_shift, dp_sample;
  logic              sout, sin;
  logic [DATA_W-1:0] rx_next;

  assign in_shift  = (state_q == ST_SHIFT);
  assign lead      = tick && !phase_q;
  assign trail     = tick &&  phase_q;
  assign last_bit  = (bit_q == '0);
  assign first_bit = (bit_q == cfg_len_m1_i);

  // edge roles per sampling option
  assign dp_sample = in_shift && (cfg_in_first_i ? lead : trail);
  assign dp_shift  = in_shift && (cfg_in_first_i ? (trail && !last_bit)
                                                 : (lead && !first_bit));
  assign sin       = cfg_loopback_i ? sout : miso_i;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .en_i   (in_shift),
    .div_i  (cfg_div_i),
    .tick_o (tick)
  );

  spi_shift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_q),
    .load_i      (dp_load),
    .load_data_i (tx_data_i),
    .len_i       (cfg_len_m1_i),
    .shift_i     (dp_shift),
    .sample_i    (dp_sample),
    .sin_i       (sin),
    .sout_o      (sout),
    .rx_next_o   (rx_next)
  );

  spi_cs_ctl #(.NUM_CS(NUM_CS)) u_cs (
    .sel_i    (cfg_cs_sel_i),
    .act_hi_i (cfg_cs_act_hi_i),
    .assert_i (busy_o || cfg_cs_force_i),
    .cs_o     (cs_o)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    bit_d    = bit_q;
    phase_d  = phase_q;
    err_d    = err_q;
    done_d   = 1'b0;
    push_d   = 1'b0;
    rxd_d    = rxd_q;
    dp_load  = 1'b0;
    tx_pop_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          left_d  = xfer_words_i;
          err_d   = '0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (left_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!tx_valid_i) begin
          err_d[ERR_UNDER] = 1'b1;
        end else begin
          tx_pop_o = 1'b1;
          dp_load  = 1'b1;
          bit_d    = cfg_len_m1_i;
          phase_d  = 1'b0;
          state_d  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          phase_d = ~phase_q;
        end
        if (trail) begin
          if (last_bit) begin
            left_d  = left_q - 1'b1;
            state_d = ST_LOAD;
            if (rx_full_i) begin
              err_d[ERR_OVER] = 1'b1;
            end else begin
              push_d = 1'b1;
              rxd_d  = rx_next;
            end
          end else begin
            bit_d = bit_q - 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      bit_q   <= '0;
      phase_q <= 1'b0;
      err_q   <= '0;
      done_q  <= 1'b0;
      push_q  <= 1'b0;
      rxd_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      phase_q <= phase_d;
      err_q   <= err_d;
      done_q  <= done_d;
      push_q  <= push_d;
      rxd_q   <= rxd_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_push_o = push_q;
  assign rx_data_o = rxd_q;
  assign err_o     = err_q;
  assign sclk_o    = cfg_clk_idle_hi_i ^ phase_q;
  assign mosi_o    = sout;
  assign sclk_oe_o = cfg_no_tri_i || busy_o;
  assign mosi_oe_o = cfg_no_tri_i || busy_o;
  assign cs_oe_o   = cfg_no_tri_i || busy_o;

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              start_i,
  input logic              sclk_o,
  input logic              cfg_clk_idle_hi_i,
  input logic              cfg_cs_act_hi_i,
  input logic              cfg_cs_force_i,
  input logic [NUM_CS-1:0] cs_o,
  input logic              cfg_no_tri_i,
  input logic              sclk_oe_o,
  input logic              mosi_oe_o,
  input logic              cs_oe_o,
  input logic              tx_pop_o,
  input logic              tx_valid_i,
  input logic              rx_push_o,
  input logic              rx_full_i,
  input logic [1:0]        err_o
);

  logic [NUM_CS-1:0] cs_idle_lvl;
  assign cs_idle_lvl = {NUM_CS{~cfg_cs_act_hi_i}};

  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o == cfg_clk_idle_hi_i); // R2

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ cs_idle_lvl) <= 1); // R5

  AST_CS_RELEASED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_cs_force_i) |-> cs_o == cs_idle_lvl); // R5

  AST_OE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_no_tri_i |-> (sclk_oe_o && mosi_oe_o && cs_oe_o)); // R6

  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i); // R7

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !$past(rx_full_i)); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[0] && !start_i) |=> err_o[0]); // R9

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10

endmodule

bind spi_shift_engine spi_shift_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .busy_o            (busy_o),
  .done_o            (done_o),
  .start_i           (start_i),
  .sclk_o            (sclk_o),
  .cfg_clk_idle_hi_i (cfg_clk_idle_hi_i),
  .cfg_cs_act_hi_i   (cfg_cs_act_hi_i),
  .cfg_cs_force_i    (cfg_cs_force_i),
  .cs_o              (cs_o),
  .cfg_no_tri_i      (cfg_no_tri_i),
  .sclk_oe_o         (sclk_oe_o),
  .mosi_oe_o         (mosi_oe_o),
  .cs_oe_o           (cs_oe_o),
  .tx_pop_o          (tx_pop_o),
  .tx_valid_i        (tx_valid_i),
  .rx_push_o         (rx_push_o),
  .rx_full_i         (rx_full_i),
  .err_o             (err_o)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_len = 5'd7;
  logic        cfg_idle = 1'b0;
  logic        cfg_in_first = 1'b1;
  logic        cfg_loop = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic        cfg_act_hi = 1'b0;
  logic        cfg_force = 1'b0;
  logic        cfg_no_tri = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        start = 1'b0;
  logic [15:0] words = 16'd0;
  logic        busy, done, tx_pop, rx_push, sclk, sclk_oe, mosi, mosi_oe, miso, cs_oe;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = 32'd0;
  logic        rx_full = 1'b0;
  logic [31:0] rx_data;
  logic [1:0]  err;
  logic [3:0]  cs;

  always #5 clk = ~clk;

  spi_shift_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_m1_i(cfg_len), .cfg_clk_idle_hi_i(cfg_idle),
    .cfg_in_first_i(cfg_in_first), .cfg_loopback_i(cfg_loop), .cfg_cs_sel_i(cfg_sel),
    .cfg_cs_act_hi_i(cfg_act_hi), .cfg_cs_force_i(cfg_force), .cfg_no_tri_i(cfg_no_tri),
    .cfg_div_i(cfg_div), .start_i(start), .xfer_words_i(words), .busy_o(busy),
    .done_o(done), .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_full_i(rx_full), .rx_data_o(rx_data), .rx_push_o(rx_push), .err_o(err),
    .sclk_o(sclk), .sclk_oe_o(sclk_oe), .mosi_o(mosi), .mosi_oe_o(mosi_oe),
    .miso_i(miso), .cs_o(cs), .cs_oe_o(cs_oe)
  );

  int n_chk = 0, n_bad = 0, pushes = 0, edges = 0, cyc = 0, lead_cyc = 0;
  bit hp_bad = 1'b0, tx_block = 1'b0, pend_pop = 1'b0, wd = 1'b0;
  bit [31:0] txq[$], slq[$], exp_rx[$], exp_mo[$];
  bit [31:0] sl_sh = 0, rcv = 0, seed = 32'h1234_5677;
  int scnt = 0;

  assign miso = sl_sh[cfg_len];

  function automatic bit [31:0] len_mask(input logic [4:0] l);
    bit [63:0] m;
    m = (64'd1 << (int'(l) + 1)) - 64'd1;
    return m[31:0];
  endfunction

  function automatic bit [31:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // transmit queue model
  always @(negedge clk) begin
    if (pend_pop && txq.size() > 0) void'(txq.pop_front());
    tx_valid = !tx_block && (txq.size() > 0);
    tx_data  = (txq.size() > 0) ? txq[0] : 32'd0;
    #1;
    pend_pop = tx_pop;
  end

  // scoreboard monitor for received words
  bit [31:0] mon_e;
  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      pushes++;
      if (exp_rx.size() == 0) begin
        chk(1'b0, "R7 push with nothing expected", rx_data, 32'd0);
      end else begin
        mon_e = exp_rx.pop_front();
        chk(rx_data == mon_e, "R7 R3 received word", rx_data, mon_e);
      end
    end
  end

  // serial target model
  logic sclk_prev = 1'b0;
  bit [31:0] mo_e;
  always @(negedge clk) begin
    if (rst_n && busy && sclk !== sclk_prev) begin
      edges++;
      if (sclk != cfg_idle) begin
        lead_cyc = cyc;
        if (cfg_in_first) begin rcv = {rcv[30:0], mosi}; scnt++; end
        else if (scnt != 0) sl_sh = sl_sh << 1;
      end else begin
        if (cyc - lead_cyc != int'(cfg_div) + 1) hp_bad = 1'b1;
        if (!cfg_in_first) begin rcv = {rcv[30:0], mosi}; scnt++; end
        if (scnt == int'(cfg_len) + 1) begin
          if (exp_mo.size() > 0) begin
            mo_e = exp_mo.pop_front();
            chk(rcv == mo_e, "R1 word seen on mosi", rcv, mo_e);
          end
          rcv = 0; scnt = 0;
          sl_sh = (slq.size() > 0) ? slq.pop_front() : 32'd0;
        end else if (cfg_in_first) begin
          sl_sh = sl_sh << 1;
        end
      end
    end
    sclk_prev = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd) begin
      wd = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      summary();
      $finish;
    end
  end

  task automatic prep(input int n, input bit loop, input bit full);
    bit [31:0] m, tw, sw;
    m = len_mask(cfg_len);
    for (int i = 0; i < n; i++) begin
      tw = next_word(); sw = next_word();
      txq.push_back(tw);
      exp_mo.push_back(tw & m);
      slq.push_back(sw);
      if (!full) exp_rx.push_back(loop ? (tw & m) : (sw & m));
    end
    rcv = 0; scnt = 0;
    sl_sh = (slq.size() > 0) ? slq.pop_front() : 32'd0;
    cfg_loop = loop; rx_full = full;
  endtask

  task automatic go(input int n);
    @(negedge clk); start = 1'b1; words = 16'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, tag, 32'(seen), 32'd1);
  endtask

  task automatic set_mode(input int m);
    cfg_idle = (m >= 2);
    cfg_in_first = (m == 0 || m == 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic full_xfer(input int n, input bit loop, input bit [3:0] exp_cs, input string tag);
    hp_bad = 1'b0;
    prep(n, loop, 1'b0);
    go(n);
    repeat (3) @(negedge clk);
    chk(cs == exp_cs, {"R5 chip select during ", tag}, 32'(cs), 32'(exp_cs));
    wait_done({"R10 done after ", tag});
    repeat (2) @(negedge clk);
    chk(exp_rx.size() == 0, {"R7 all words returned ", tag}, exp_rx.size(), 0);
    chk(exp_mo.size() == 0, {"R1 all words sent ", tag}, exp_mo.size(), 0);
    chk(!hp_bad, {"R2 half period ", tag}, 32'(hp_bad), 0);
  endtask

  int e0, p0;
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk(cs == 4'hF, "R5 reset chip select", 32'(cs), 32'hF);
    chk(sclk == 1'b0 && busy == 1'b0, "R2 reset clock idle", {sclk, busy}, 0);
    chk(err == 2'b00, "R8 R9 reset errors", 32'(err), 0);
    chk({sclk_oe, mosi_oe, cs_oe} == 3'b000, "R6 tristate while idle", 32'({sclk_oe, mosi_oe, cs_oe}), 0);

    // mode 0, 8-bit words
    set_mode(0); cfg_len = 5'd7; cfg_div = 8'd1; cfg_sel = 2'd0;
    full_xfer(4, 1'b0, 4'b1110, "mode0");
    // mode 1
    set_mode(1); cfg_div = 8'd2; cfg_sel = 2'd1;
    full_xfer(3, 1'b0, 4'b1101, "mode1");
    // mode 2, 5-bit words, active-high chip select, fastest divider
    set_mode(2); cfg_len = 5'd4; cfg_div = 8'd0; cfg_sel = 2'd2; cfg_act_hi = 1'b1;
    full_xfer(3, 1'b0, 4'b0100, "mode2");
    chk(sclk == 1'b1, "R2 idle high after mode2", 32'(sclk), 1);
    cfg_act_hi = 1'b0;
    // mode 3, 32-bit words
    set_mode(3); cfg_len = 5'd31; cfg_div = 8'd1; cfg_sel = 2'd3;
    full_xfer(2, 1'b0, 4'b0111, "mode3");
    // loopback, 16-bit, mode 1
    set_mode(1); cfg_len = 5'd15;
    full_xfer(3, 1'b1, 4'b0111, "R4 loopback");
    cfg_loop = 1'b0;

    // forced chip select and no-tristate while idle
    cfg_force = 1'b1; cfg_sel = 2'd2; cfg_no_tri = 1'b1;
    @(negedge clk);
    chk(cs == 4'b1011, "R5 forced chip select idle", 32'(cs), 32'hB);
    chk({sclk_oe, mosi_oe, cs_oe} == 3'b111, "R6 outputs kept driven", 32'({sclk_oe, mosi_oe, cs_oe}), 7);
    cfg_force = 1'b0; cfg_no_tri = 1'b0;

    // zero-word transfer
    set_mode(0); cfg_len = 5'd7;
    e0 = edges; p0 = pushes;
    go(0);
    wait_done("R10 done for zero words");
    chk(edges == e0 && pushes == p0, "R10 zero words gives no clock", 32'(edges - e0), 0);

    // underrun stall
    tx_block = 1'b1;
    prep(2, 1'b0, 1'b0);
    e0 = edges;
    go(2);
    repeat (20) @(negedge clk);
    chk(err[0] == 1'b1, "R9 underrun flag", 32'(err), 1);
    chk(busy && sclk == cfg_idle && edges == e0, "R9 stalled with clock idle", 32'(edges - e0), 0);
    tx_block = 1'b0;
    wait_done("R9 resumes after data");
    @(negedge clk);
    chk(exp_rx.size() == 0, "R9 words delivered after stall", exp_rx.size(), 0);
    chk(err[0] == 1'b1, "R9 underrun flag sticky", 32'(err), 1);

    // overrun: receive queue full throughout
    p0 = pushes;
    prep(2, 1'b0, 1'b1);
    go(2);
    chk(err == 2'b00, "R10 start clears errors", 32'(err), 0);
    wait_done("R8 done under overrun");
    @(negedge clk);
    chk(err[1] == 1'b1, "R8 overrun flag", 32'(err), 2);
    chk(pushes == p0, "R8 no push when full", 32'(pushes - p0), 0);
    rx_full = 1'b0;

    // start while busy is ignored
    p0 = pushes;
    prep(3, 1'b0, 1'b0);
    go(3);
    repeat (10) @(negedge clk);
    start = 1'b1; words = 16'd5;
    @(negedge clk); start = 1'b0;
    wait_done("R10 done with ignored restart");
    repeat (3) @(negedge clk);
    chk(pushes - p0 == 3, "R10 restart ignored word count", 32'(pushes - p0), 3);
    chk(err == 2'b00 && !busy, "R10 no underrun from restart", 32'(err), 0);

    summary();
    $finish;
  end

endmodule